// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block connects a single-request synchronous port to an external asynchronous static memory of 131,072 bytes. The host presents one request at a time: a direction flag, a 17-bit word address and, for stores, an 8-bit data byte. The controller then runs the memory pins through a fixed cycle sequence and reports completion with a one-cycle pulse. For a load, this pulse comes with the byte that was read.

The memory has two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and a bidirectional byte lane. The lane is modelled as a separate outgoing byte, an incoming byte and a drive-enable. Every wait state comes from two parameters: the clock period in picoseconds and a speed-grade index. From these the block computes, rounding up, how many cycles the access time spans. While a sequence is running, the ready output is low, so the host keeps its request on the port until it is accepted.

Top module: `sram_bus_ctrl`

## Requirements
- R1: Out of reset, and on every cycle in which `req_ready` is high, the memory is in standby. This means `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. Reset also leaves `rsp_done`=0.
- R2: A read (`req_write`=0) holds `mem_oe_n` low for exactly WAIT cycles. During that time `mem_cs_n`=0, `mem_cs`=1, `mem_we_n`=1 and the accepted address is on `mem_addr`. The byte on `mem_dq_in` in the last of those cycles appears on `rsp_rdata` while `rsp_done` is high.
- R3: A write (`req_write`=1) runs three phases. First comes one setup cycle with the lane driven and `mem_we_n` high. Then `mem_we_n` is low for exactly WAIT cycles. Last comes one hold cycle in which `mem_we_n` is high again and the chip selects, address and driven byte are all unchanged. The memory latches the byte on the rising edge of `mem_we_n`.
- R4: `mem_dq_oe` is never high while `mem_oe_n` is low or while the memory is deselected.
- R5: After a read, the first cycle with `mem_oe_n` high has the lane released and `req_ready` low. So a following write is accepted no earlier than one further cycle.
- R6: `req_ready` is low from the cycle after acceptance until the sequence ends. A request held on the port during that time is accepted later, and every accepted request produces exactly one `rsp_done`, in order.
- R7: WAIT = ceil(access_ns × 1000 / CLK_PERIOD_PS), with a minimum of 1. Access_ns is 10, 12, 15 or 20 for `SPEED_GRADE` 0, 1, 2 or 3.
- R8: `rsp_done` is high for one cycle at a time. For a read it rises in the cycle after the last output-enable cycle. For a write it rises in the cycle after the hold cycle.
- R9: Address and data are captured at acceptance. Changes on `req_addr` and `req_wdata` after acceptance have no effect on the stored or returned byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to store |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 17 | Address to memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven onto the lane |
| mem_dq_oe | output | 1 | Drive-enable for the lane |
| mem_dq_in | input | 8 | Byte read from the lane |

## Verification
A write's completion pulse and the acceptance of the next request land in the same cycle. The pulse appears in the first idle cycle, which is also the first cycle in which `req_ready` is high. The bench provokes this by issuing requests back to back, so the next one is already waiting on the port as a write finishes. The scoreboard then shows whether that response is lost, duplicated or reordered. Read data is compared against a reference copy, and the output-enable and write-strobe widths are counted cycle by cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD
    } seq_st_e;

    // Access time in ns for each speed-grade index
    function automatic int unsigned grade_ns(input int unsigned grade);
        case (grade)
            0:       return 10;
            1:       return 12;
            2:       return 15;
            default: return 20;
        endcase
    endfunction

    // Cycles covering a time span, rounded up, never below one
    function automatic int unsigned span_cycles(input int unsigned ns,
                                                input int unsigned clk_ps);
        int unsigned c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = capture ? din : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned SPEED_GRADE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned WAIT_CYC = span_cycles(grade_ns(SPEED_GRADE), CLK_PERIOD_PS);
    localparam int unsigned CNT_W    = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(WAIT_CYC - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              sel;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic              done;
    } ctl_s;

    localparam ctl_s CTL_RST = '{st: ST_IDLE, addr: '0, wdata: '0, sel: 1'b0,
                                 we_n: 1'b1, oe_n: 1'b1, drv: 1'b0, done: 1'b0};

    ctl_s ctl_d, ctl_q;
    logic tmr_load, tmr_expired, cap;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (LOAD_V),
        .expired  (tmr_expired)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .din     (mem_dq_in),
        .rdata   (rsp_rdata)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load = 1'b0;
        cap      = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr = req_addr;
                    ctl_d.sel  = 1'b1;
                    if (req_write) begin
                        ctl_d.wdata = req_wdata;
                        ctl_d.drv   = 1'b1;
                        ctl_d.st    = ST_WSETUP;
                    end else begin
                        ctl_d.oe_n = 1'b0;
                        ctl_d.st   = ST_READ;
                        tmr_load   = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (tmr_expired) begin
                    cap        = 1'b1;
                    ctl_d.done = 1'b1;
                    ctl_d.oe_n = 1'b1;
                    ctl_d.sel  = 1'b0;
                    ctl_d.st   = ST_TURN;
                end
            end
            ST_TURN: begin
                ctl_d.st = ST_IDLE;
            end
            ST_WSETUP: begin
                ctl_d.we_n = 1'b0;
                ctl_d.st   = ST_WPULSE;
                tmr_load   = 1'b1;
            end
            ST_WPULSE: begin
                if (tmr_expired) begin
                    ctl_d.we_n = 1'b1;
                    ctl_d.st   = ST_WHOLD;
                end
            end
            ST_WHOLD: begin
                ctl_d.sel  = 1'b0;
                ctl_d.drv  = 1'b0;
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign req_ready  = (ctl_q.st == ST_IDLE);
    assign rsp_done   = ctl_q.done;
    assign mem_addr   = ctl_q.addr;
    assign mem_cs_n   = ~ctl_q.sel;
    assign mem_cs     = ctl_q.sel;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.drv;

    // R1: idle means standby with the lane released
    p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R2: output enable only with both selects active and write strobe high
    p_read_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_cs && mem_we_n));

    // R3: write strobe rises with address and data held and still driven
    p_we_rise_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && mem_cs && $stable(mem_addr) && $stable(mem_dq_out)));

    // R4: no drive while the memory may drive
    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

    // R5: turnaround cycle after a read
    p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (!mem_dq_oe && !req_ready));

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/sram_bus_ctrl_bench.sv
module sram_bus_ctrl_bench;
    localparam int unsigned CLK_PS   = 8000;
    localparam int unsigned GRADE    = 3;
    // 20 ns at 8 ns per cycle, rounded up
    localparam int EXP_WAIT = (20 * 1000 + 8000 - 1) / 8000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [16:0] req_addr;
    logic [7:0]  req_wdata;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    always #4 clk = ~clk;

    sram_bus_ctrl #(.CLK_PERIOD_PS(CLK_PS), .SPEED_GRADE(GRADE)) u_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Memory model: latch on rising write strobe, drive when fully enabled
    logic [7:0] mem_m [int];
    logic [7:0] ref_m [int];

    always @(posedge mem_we_n)
        if (rst_n && !mem_cs_n && mem_cs && mem_dq_oe)
            mem_m[int'(mem_addr)] = mem_dq_out;

    always @* begin
        if (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n)
            mem_dq_in = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h5A;
        else
            mem_dq_in = 8'hEE;
    end

    typedef struct {
        bit         wr;
        logic [7:0] d;
    } exp_t;
    exp_t exp_q[$];
    int n_acc = 0;
    int n_done = 0;

    // Driver: hold request until accepted, then scramble the fields (R9)
    task automatic send(input bit wr, input logic [16:0] a, input logic [7:0] d);
        exp_t e;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        e.wr = wr;
        if (wr) begin
            ref_m[int'(a)] = d;
            e.d = d;
        end else begin
            e.d = ref_m.exists(int'(a)) ? ref_m[int'(a)] : 8'h5A;
        end
        exp_q.push_back(e);
        n_acc++;
        @(negedge clk);
        check(!req_ready, "R6 ready low after accept", int'(req_ready), 0);
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~d;
    endtask

    // Monitor
    int  oe_cnt = 0;
    int  we_cnt = 0;
    bit  prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_done) begin
                n_done++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (!e.wr)
                        check(rsp_rdata == e.d, "R2/R9 read data", int'(rsp_rdata), int'(e.d));
                end
            end
            if (rsp_done && prev_done) check(1'b0, "R8 done width", 2, 1);
            prev_done = rsp_done;
            if (mem_dq_oe && !mem_oe_n) check(1'b0, "R4 contention", 1, 0);
            if (req_ready)
                check(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe,
                      "R1 idle standby", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
            if (!mem_oe_n) begin
                oe_cnt++;
            end else if (oe_cnt != 0) begin
                check(oe_cnt == EXP_WAIT, "R2/R7 read width", oe_cnt, EXP_WAIT);
                check(!mem_dq_oe && !req_ready, "R5 turnaround", {mem_dq_oe, req_ready}, 0);
                check(rsp_done, "R8 read done timing", int'(rsp_done), 1);
                oe_cnt = 0;
            end
            if (!mem_we_n) begin
                we_cnt++;
            end else if (we_cnt != 0) begin
                check(we_cnt == EXP_WAIT, "R3/R7 write width", we_cnt, EXP_WAIT);
                check(mem_dq_oe && mem_cs && !mem_cs_n, "R3 hold cycle", {mem_dq_oe, mem_cs, mem_cs_n}, 3'b110);
                we_cnt = 0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_done, n_acc);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 reset pins",
              {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        check(req_ready && !rsp_done, "R1 reset ready/done", {req_ready, rsp_done}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);

        // Boundary addresses, back-to-back (R6 stall, write done meets next accept)
        send(1'b1, 17'h00000, 8'hA5);
        send(1'b1, 17'h1FFFF, 8'h3C);
        send(1'b0, 17'h00000, 8'h00);
        send(1'b0, 17'h1FFFF, 8'h00);
        // Read then write immediately (R5)
        send(1'b0, 17'h00000, 8'h00);
        send(1'b1, 17'h00000, 8'h77);
        send(1'b0, 17'h00000, 8'h00);
        // Unwritten location
        send(1'b0, 17'h0ABCD, 8'h00);
        // Spread pattern
        for (int i = 0; i < 16; i++)
            send(1'b1, 17'((i * 4099) & 17'h1FFFF), 8'((i * 37) ^ 8'h96));
        for (int i = 15; i >= 0; i--)
            send(1'b0, 17'((i * 4099) & 17'h1FFFF), 8'h00);
        // Alternating read/write on one address
        for (int i = 0; i < 6; i++) begin
            send(1'b1, 17'h12345, 8'(i * 17 + 3));
            send(1'b0, 17'h12345, 8'h00);
        end

        for (int k = 0; k < 50 && exp_q.size() != 0; k++) @(negedge clk);
        check(exp_q.size() == 0, "R6 all responses", exp_q.size(), 0);
        check(n_done == n_acc, "R6 done count", n_done, n_acc);
        repeat (3) @(negedge clk);
        check(req_ready && !rsp_done, "R1 final idle", {req_ready, rsp_done}, 2'b10);
        finish_run();
    end

endmodule